// File: doc/BRIEF.md
# SCSI Message-In Byte Queue

This block holds the bytes the host adapter has to hand to the initiator side during a message-in bus phase. The controller fills it one byte at a time, or with one of three canned sequences (reselection, status completion, deferred command). Each fill also records the action that follows the message: go to command, disconnect, data-out or data-in. A drain request names a byte count. The block then streams out the smaller of that count and the queued length, one byte per accepted transfer. Bytes left after a partial drain move up to the front for the next drain.

Only the drain that empties the queue raises the follow-on action pulse. The front byte is always visible on `head_byte`. The last byte of the most recent drain is held on `last_byte`. A data-bus peek returns the front byte, but only while the bus phase input reads message-in.

The byte stream out is valid/ready. `out_valid` stays high with `out_data` unchanged until `out_ready` is seen. Drain requests are valid/ready too: `drain_ready` is high only while no drain is in progress. The fill side is not back-pressured, because a full queue is defined to drop the extra byte and flag an overflow.

Top module: `msgq_top`

## Requirements
- R1: The queue holds at most DEPTH (8) bytes. A byte appended to a full queue is dropped, and `push_overflow` is high for the one cycle after the offending fill. The bytes already queued are kept.
- R2: An accepted drain streams exactly min(`drain_count`, queued length) bytes on `out_data`, oldest first, one per cycle in which `out_valid` and `out_ready` are both high.
- R3: A drain accepted while the queue is empty delivers no byte and raises no action pulse. `drain_ready` stays high.
- R4: `head_byte` shows the front byte, and 0 when the queue is empty. `last_byte` shows the final byte delivered by the latest non-empty drain, and 0 after reset.
- R5: After a partial drain, the bytes not delivered stay queued in their order and are delivered first by the next drain.
- R6: `act_valid` pulses for one cycle, the cycle after the byte that empties the queue is taken. `act_code` carries the stored action: 0 command, 1 disconnect, 2 data-out, 3 data-in. No other drain pulses it.
- R7: A reselection load (`load_kind` 0) queues 0x80. When `resel_tag_valid` is set it then queues 0x20 and `resel_tag`. The stored action becomes 2 if `resel_out` is 1, else 3.
- R8: A status load (`load_kind` 1) queues 0x00. A deferred-command load (`load_kind` 2) queues 0x02 then 0x04. Both store action 1.
- R9: `bus_peek` equals `head_byte` when `bus_phase` is 3'b111 (message-in), and 0 for every other phase.
- R10: While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_data` holds on the next cycle.
- R11: After reset the queue is empty, `drain_ready` is high, and `out_valid`, `act_valid` and `push_overflow` are low.
- R12: A plain push (`push_valid`) queues `push_data` and stores `push_action` as the follow-on action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_valid | input | 1 | Append one byte |
| push_data | input | DW | Byte to append |
| push_action | input | 2 | Follow-on action stored with the push |
| load_valid | input | 1 | Append a canned sequence |
| load_kind | input | 2 | 0 reselection, 1 status, 2 deferred command, 3 none |
| resel_tag | input | 8 | Queue tag for reselection |
| resel_tag_valid | input | 1 | Reselection carries a tag |
| resel_out | input | 1 | Reselected command moves data out |
| push_overflow | output | 1 | A byte was dropped on the previous fill |
| drain_valid | input | 1 | Drain request |
| drain_count | input | CNT_W | Requested byte count |
| drain_ready | output | 1 | No drain in progress |
| out_valid | output | 1 | Drained byte present |
| out_data | output | DW | Drained byte |
| out_ready | input | 1 | Consumer takes the byte |
| head_byte | output | DW | Front byte of the queue |
| last_byte | output | DW | Last byte of the latest drain |
| bus_phase | input | 3 | Current bus phase |
| bus_peek | output | DW | Data-bus peek value |
| act_valid | output | 1 | Follow-on action pulse |
| act_code | output | 2 | Follow-on action code |

## Verification
The assertions assume that `push_valid` and `load_valid` never arrive in the same cycle. They also assume that no fill lands in the cycle of the final pop, so the queue length seen after an action pulse matches the drain alone. The stimulus keeps to this by running fills, drains and peeks as separate phases, each completing before the next starts. Back-pressure is applied through stall cycles between accepted bytes. A drain request is only raised while `drain_ready` is high.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  typedef enum logic [1:0] {
    ACT_CMD  = 2'd0,
    ACT_DISC = 2'd1,
    ACT_DOUT = 2'd2,
    ACT_DIN  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LD_RESEL  = 2'd0,
    LD_STATUS = 2'd1,
    LD_DEFER  = 2'd2,
    LD_NONE   = 2'd3
  } load_e;

  localparam logic [2:0] PH_MSGIN  = 3'b111;
  localparam int         MAX_APPEND = 3;

  localparam logic [7:0] MB_IDENT    = 8'h80;
  localparam logic [7:0] MB_SIMPLE_Q = 8'h20;
  localparam logic [7:0] MB_CMD_DONE = 8'h00;
  localparam logic [7:0] MB_SAVE_DP  = 8'h02;
  localparam logic [7:0] MB_DISCON   = 8'h04;
endpackage

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int NAPP  = 3,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(NAPP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pop,
  input  logic [NW-1:0]           app_n,
  input  logic [NAPP-1:0][DW-1:0] app_bytes,
  output logic [DW-1:0]           head,
  output logic [LW-1:0]           len,
  output logic [LW-1:0]           len_nxt,
  output logic                    ovf
);
  logic [DW-1:0] q   [DEPTH];
  logic [DW-1:0] q_n [DEPTH];
  logic          ovf_n;

  always_comb begin
    int base;
    int tot;
    base = int'(len) - (pop ? 1 : 0);
    for (int k = 0; k < DEPTH; k++) begin
      if (pop) q_n[k] = (k == DEPTH - 1) ? '0 : q[k+1];
      else     q_n[k] = q[k];
    end
    for (int i = 0; i < NAPP; i++) begin
      if (i < int'(app_n) && base + i < DEPTH) q_n[base+i] = app_bytes[i];
    end
    tot     = base + int'(app_n);
    ovf_n   = tot > DEPTH;
    len_nxt = ovf_n ? LW'(DEPTH) : LW'(tot);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= q_n[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
      ovf <= 1'b0;
    end else begin
      len <= len_nxt;
      ovf <= ovf_n;
    end
  end

  assign head = q[0];
endmodule

// File: rtl/msgq_drain.sv
module msgq_drain #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drain_valid,
  input  logic [CNT_W-1:0] drain_count,
  output logic             drain_ready,
  input  logic [LW-1:0]    q_len,
  input  logic [LW-1:0]    q_len_nxt,
  input  logic [DW-1:0]    head,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  output logic             pop,
  output logic             fire,
  output logic [DW-1:0]    last_byte
);
  logic          busy;
  logic [LW-1:0] remain;
  logic [LW-1:0] take;
  logic          final_pop;

  always_comb begin
    if (longint'(drain_count) < longint'(q_len)) take = LW'(drain_count);
    else                                         take = q_len;
  end

  assign drain_ready = !busy;
  assign out_valid   = busy;
  assign out_data    = head;
  assign pop         = busy && out_ready;
  assign final_pop   = pop && (remain == LW'(1));
  assign fire        = final_pop && (q_len_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      last_byte <= '0;
    end else if (!busy) begin
      if (drain_valid && take != '0) begin
        busy   <= 1'b1;
        remain <= take;
      end
    end else if (pop) begin
      remain <= remain - LW'(1);
      if (final_pop) begin
        busy      <= 1'b0;
        last_byte <= head;
      end
    end
  end
endmodule

// File: rtl/msgq_top.sv
module msgq_top
  import msgq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(MAX_APPEND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic [1:0]       push_action,
  input  logic             load_valid,
  input  logic [1:0]       load_kind,
  input  logic [7:0]       resel_tag,
  input  logic             resel_tag_valid,
  input  logic             resel_out,
  output logic             push_overflow,
  input  logic             drain_valid,
  input  logic [CNT_W-1:0] drain_count,
  output logic             drain_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  output logic [DW-1:0]    head_byte,
  output logic [DW-1:0]    last_byte,
  input  logic [2:0]       bus_phase,
  output logic [DW-1:0]    bus_peek,
  output logic             act_valid,
  output logic [1:0]       act_code
);
  logic [NW-1:0]                app_n;
  logic [MAX_APPEND-1:0][DW-1:0] app_b;
  logic                         act_set;
  act_e                         act_q, act_nxt;
  logic [LW-1:0]                q_len, q_len_nxt;
  logic                         pop, fire;

  always_comb begin
    app_n   = '0;
    app_b   = '0;
    act_set = 1'b0;
    act_nxt = act_q;
    if (load_valid) begin
      unique case (load_e'(load_kind))
        LD_RESEL: begin
          act_set  = 1'b1;
          act_nxt  = resel_out ? ACT_DOUT : ACT_DIN;
          app_b[0] = DW'(MB_IDENT);
          if (resel_tag_valid) begin
            app_b[1] = DW'(MB_SIMPLE_Q);
            app_b[2] = DW'(resel_tag);
            app_n    = NW'(3);
          end else begin
            app_n = NW'(1);
          end
        end
        LD_STATUS: begin
          act_set  = 1'b1;
          act_nxt  = ACT_DISC;
          app_b[0] = DW'(MB_CMD_DONE);
          app_n    = NW'(1);
        end
        LD_DEFER: begin
          act_set  = 1'b1;
          act_nxt  = ACT_DISC;
          app_b[0] = DW'(MB_SAVE_DP);
          app_b[1] = DW'(MB_DISCON);
          app_n    = NW'(2);
        end
        default: ;
      endcase
    end else if (push_valid) begin
      act_set  = 1'b1;
      act_nxt  = act_e'(push_action);
      app_b[0] = push_data;
      app_n    = NW'(1);
    end
  end

  msgq_store #(.DEPTH(DEPTH), .DW(DW), .NAPP(MAX_APPEND)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .app_n     (app_n),
    .app_bytes (app_b),
    .head      (head_byte),
    .len       (q_len),
    .len_nxt   (q_len_nxt),
    .ovf       (push_overflow)
  );

  msgq_drain #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .drain_valid (drain_valid),
    .drain_count (drain_count),
    .drain_ready (drain_ready),
    .q_len       (q_len),
    .q_len_nxt   (q_len_nxt),
    .head        (head_byte),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .pop         (pop),
    .fire        (fire),
    .last_byte   (last_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= ACT_CMD;
      act_valid <= 1'b0;
      act_code  <= '0;
    end else begin
      if (act_set) act_q <= act_nxt;
      act_valid <= fire;
      if (fire) act_code <= act_q;
    end
  end

  assign bus_peek = (bus_phase == PH_MSGIN) ? head_byte : '0;
endmodule

// File: rtl/msgq_chk.sv
module msgq_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] q_len,
  input logic          push_overflow,
  input logic          drain_valid,
  input logic          drain_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          act_valid
);
  a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_len <= LW'(DEPTH));

  a_r1_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_overflow |-> q_len == LW'(DEPTH));

  a_r2_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> q_len != '0);

  a_r3_empty_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && drain_ready && q_len == '0) |=> (drain_ready && !out_valid));

  a_r6_act_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(out_valid && out_ready));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind msgq_top msgq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .q_len         (q_len),
  .push_overflow (push_overflow),
  .drain_valid   (drain_valid),
  .drain_ready   (drain_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .act_valid     (act_valid)
);

// File: tb/tb_msgq_top.sv
module tb_msgq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic [1:0] push_action = '0;
  logic       load_valid = 1'b0;
  logic [1:0] load_kind = 2'd3;
  logic [7:0] resel_tag = '0;
  logic       resel_tag_valid = 1'b0;
  logic       resel_out = 1'b0;
  logic       push_overflow;
  logic       drain_valid = 1'b0;
  logic [7:0] drain_count = '0;
  logic       drain_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic [7:0] head_byte, last_byte, bus_peek;
  logic [2:0] bus_phase = '0;
  logic       act_valid;
  logic [1:0] act_code;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [32];
  int mlen = 0;
  int mact = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msgq_top dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_action(push_action), .load_valid(load_valid), .load_kind(load_kind),
    .resel_tag(resel_tag), .resel_tag_valid(resel_tag_valid), .resel_out(resel_out),
    .push_overflow(push_overflow), .drain_valid(drain_valid), .drain_count(drain_count),
    .drain_ready(drain_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .head_byte(head_byte), .last_byte(last_byte),
    .bus_phase(bus_phase), .bus_peek(bus_peek), .act_valid(act_valid), .act_code(act_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_add(input logic [7:0] b, output bit dropped);
    dropped = (mlen >= DEPTH);
    if (!dropped) begin
      mdl[mlen] = b;
      mlen++;
    end
  endtask

  task automatic do_push(input logic [7:0] b, input int act);
    bit d;
    @(negedge clk);
    push_valid = 1'b1; push_data = b; push_action = 2'(act);
    @(negedge clk);
    push_valid = 1'b0;
    m_add(b, d);
    mact = act;
    chk(push_overflow == d, d ? "R1 overflow on full push" : "R12 push no overflow",
        int'(push_overflow), int'(d));
  endtask

  task automatic do_load(input int kind, input bit tv, input logic [7:0] tg, input bit dout);
    bit d, any;
    @(negedge clk);
    load_valid = 1'b1; load_kind = 2'(kind);
    resel_tag_valid = tv; resel_tag = tg; resel_out = dout;
    @(negedge clk);
    load_valid = 1'b0; load_kind = 2'd3;
    any = 1'b0;
    if (kind == 0) begin
      m_add(8'h80, d); any |= d;
      if (tv) begin m_add(8'h20, d); any |= d; m_add(tg, d); any |= d; end
      mact = dout ? 2 : 3;
    end else if (kind == 1) begin
      m_add(8'h00, d); any |= d; mact = 1;
    end else begin
      m_add(8'h02, d); any |= d; m_add(8'h04, d); any |= d; mact = 1;
    end
    chk(push_overflow == any, "R1 R7 R8 load overflow flag", int'(push_overflow), int'(any));
  endtask

  task automatic do_drain(input int cnt, input int seed);
    int n;
    bit exp_fire;
    logic [7:0] lastb;
    n = (cnt < mlen) ? cnt : mlen;
    exp_fire = (n > 0) && (n == mlen);
    @(negedge clk);
    chk(drain_ready == 1'b1, "R3 drain_ready before request", int'(drain_ready), 1);
    drain_valid = 1'b1; drain_count = 8'(cnt);
    @(negedge clk);
    drain_valid = 1'b0;
    if (n == 0) begin
      chk(!out_valid && drain_ready, "R3 empty drain stays idle", int'(out_valid), 0);
      @(negedge clk);
      chk(act_valid == 1'b0, "R3 no action on empty drain", int'(act_valid), 0);
      return;
    end
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s < (k + seed) % 3; s++) begin
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid && out_data == mdl[k], "R10 data held under stall", int'(out_data), int'(mdl[k]));
      end
      chk(out_valid && out_data == mdl[k], "R2 R5 delivered byte", int'(out_data), int'(mdl[k]));
      chk(act_valid == 1'b0, "R6 no action before final byte", int'(act_valid), 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    lastb = mdl[n-1];
    chk(!out_valid && drain_ready, "R2 stream stops after count", int'(out_valid), 0);
    chk(act_valid == exp_fire, "R6 action pulse", int'(act_valid), int'(exp_fire));
    if (exp_fire) chk(int'(act_code) == mact, "R6 action code", int'(act_code), mact);
    chk(last_byte == lastb, "R4 last byte", int'(last_byte), int'(lastb));
    for (int k = 0; k + n < mlen; k++) mdl[k] = mdl[k+n];
    mlen -= n;
    chk(head_byte == (mlen > 0 ? mdl[0] : 8'h00), "R4 R5 head byte after drain",
        int'(head_byte), mlen > 0 ? int'(mdl[0]) : 0);
    @(negedge clk);
    chk(act_valid == 1'b0, "R6 action is one cycle", int'(act_valid), 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drain_ready && !out_valid && !act_valid && !push_overflow, "R11 reset outputs",
        int'({drain_ready, out_valid, act_valid, push_overflow}), 8);
    chk(head_byte == 0 && last_byte == 0, "R11 R4 reset bytes", int'(head_byte), 0);

    // R2 R5 R6 R12: sweep queued length and requested count
    for (int fill = 0; fill <= DEPTH; fill++) begin
      for (int cnt = 0; cnt <= 9; cnt++) begin
        for (int i = 0; i < fill; i++)
          do_push(8'((fill * 16 + i) ^ (cnt * 3)), (fill + cnt + i) % 4);
        if (fill > 0)
          chk(head_byte == mdl[0], "R4 head after fill", int'(head_byte), int'(mdl[0]));
        do_drain(cnt, fill + cnt);
        do_drain(15, cnt);
      end
    end

    // R1: overflow on ninth byte
    for (int i = 0; i < DEPTH + 1; i++) do_push(8'(8'hA0 + i), 1);
    do_drain(12, 0);
    chk(mlen == 0, "R1 only eight bytes kept", mlen, 0);
    for (int i = 0; i < DEPTH - 1; i++) do_push(8'(i), 0);
    do_load(0, 1'b1, 8'h3C, 1'b1);
    do_drain(20, 1);

    // R7: reselection with and without tag
    do_load(0, 1'b1, 8'h5A, 1'b1);
    do_drain(3, 2);
    do_load(0, 1'b0, 8'hFF, 1'b0);
    do_drain(4, 0);

    // R8: status and deferred command, with partial drain of the latter
    do_load(1, 1'b0, 8'h00, 1'b0);
    do_drain(1, 1);
    do_load(2, 1'b0, 8'h00, 1'b0);
    do_drain(1, 0);
    do_drain(1, 2);

    // R9: peek across all phases
    do_load(2, 1'b0, 8'h00, 1'b0);
    for (int ph = 0; ph < 8; ph++) begin
      @(negedge clk);
      bus_phase = 3'(ph);
      #1;
      chk(bus_peek == (ph == 7 ? 8'h02 : 8'h00), "R9 bus peek", int'(bus_peek), ph == 7 ? 2 : 0);
    end
    do_drain(2, 0);
    #1;
    chk(bus_peek == 8'h00, "R9 peek empty in msg-in", int'(bus_peek), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule